// File: doc/BRIEF.md
# Resistor Ladder Key Decoder

This block turns the readings of a single analog key line into a debounced button code. Nine buttons share the line through a resistor divider, so each button pulls it to its own voltage. An ADC delivers 10-bit conversions of that voltage, marked by a valid strobe. A separate active-low flag goes low while any button is held down. The decoder places each reading into one of nine voltage windows and confirms it over several readings. It then reports which button is held, with a one-cycle pulse when the press is reported and another when it ends.

The window edges sit halfway between neighbouring nominal codes. The nominal codes are 0, 204, 304, 398, 496, 592, 688, 784 and 880, one ADC step being 3.0 V / 1024. A reading above the point halfway between the highest level and full scale matches no button. A button is reported only after a run of identical decodes taken while the flag is low. Once a button is reported, no other button can be reported until a release has been seen. The converter and the divider are outside the block. A wider converter is handled by scaling the nominal codes up to the wider range.

Top module: `lkd_key_decoder`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, key_valid, press_evt and release_evt are 0 and key_code is 15.
- R2: A valid reading v maps to key index k (0 record, 1 to 4 the application buttons, 5 up, 6 right, 7 left, 8 down) when v is above the upper edge of window k-1 and at most the upper edge of window k. The upper edge of window k is the truncated mean of nominal codes k and k+1. With the default width the upper edges are 102, 254, 351, 447, 544, 640, 736, 832 and 951.
- R3: A valid reading above the top window edge (951 at 10 bits, which is the mean of 880 and full scale) decodes as no key and never produces a report.
- R4: In any cycle with key_flag_n high, the run of matching readings is cleared, and any held key is released.
- R5: A key is reported (key_valid 1, key_code the index) in the cycle after the STABLE_N-th consecutive valid reading that decodes to the same key with key_flag_n low (default STABLE_N is 4).
- R6: press_evt is high for exactly the one cycle in which a new report first appears. It is never high together with release_evt.
- R7: A held key is released by key_flag_n high, or by a valid reading that decodes as no key. In the next cycle release_evt pulses for one cycle, key_valid is 0 and key_code is 15.
- R8: While a key is held, readings that decode to a different key leave key_code unchanged and produce no press_evt.
- R9: Cycles with sample_valid low neither advance nor break a run of matching readings.
- R10: After a release, a new report needs a fresh run of STABLE_N matching readings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | sample_code holds a new conversion this cycle |
| sample_code | input | ADC_W | Converted level of the key line |
| key_flag_n | input | 1 | Low while any button is held |
| key_valid | output | 1 | A debounced key is being reported |
| key_code | output | 4 | Reported key index, 15 when none |
| press_evt | output | 1 | One-cycle pulse when a report starts |
| release_evt | output | 1 | One-cycle pulse when a report ends |

## Verification
The bench probes both sides of every window edge, for example 254 and 255, and the top edge at 951 and 952. An off-by-one comparator would report the neighbouring key, or would report down for a reading that should mean no key. Runs are broken in three ways: by a different reading, by a single flag-high cycle, and by idle gaps that must not break them. A counter that ignored the gaps or the flag would report one reading too early or too late. Readings of a different key while one is held, and a re-press straight after a release, expose a decoder that switches keys in place or reuses a stale run.

// File: rtl/lkd_pkg.sv
package lkd_pkg;

   localparam int unsigned LKD_KEYS   = 9;
   localparam int unsigned LKD_CODE_W = 4;

   typedef logic [LKD_CODE_W-1:0] lkd_key_t;

   localparam lkd_key_t LKD_NONE = 4'hF;

   // nominal ladder code of each button at 10-bit resolution
   function automatic int unsigned lkd_level10(input int unsigned idx);
      case (idx)
         0:       return 0;
         1:       return 204;
         2:       return 304;
         3:       return 398;
         4:       return 496;
         5:       return 592;
         6:       return 688;
         7:       return 784;
         8:       return 880;
         default: return 0;
      endcase
   endfunction

   // upper inclusive edge of the window of button idx at adc_w bits
   function automatic int unsigned lkd_window_top(input int unsigned idx,
                                                  input int unsigned adc_w);
      int unsigned sh;
      int unsigned lo;
      int unsigned hi;
      sh = adc_w - 10;
      lo = lkd_level10(idx) << sh;
      if (idx + 1 < LKD_KEYS)
         hi = lkd_level10(idx + 1) << sh;
      else
         hi = (32'd1 << adc_w) - 1;
      return (lo + hi) / 2;
   endfunction

endpackage

// File: rtl/lkd_window_decode.sv
module lkd_window_decode
   import lkd_pkg::*;
#(
   parameter int unsigned ADC_W = 10
) (
   input  logic [ADC_W-1:0] sample,
   output lkd_key_t         key
);

   logic [LKD_KEYS-1:0] at_or_below;

   for (genvar k = 0; k < LKD_KEYS; k++) begin : g_win
      localparam int unsigned   TOP   = lkd_window_top(k, ADC_W);
      localparam logic [ADC_W-1:0] TOP_V = ADC_W'(TOP);
      assign at_or_below[k] = (sample <= TOP_V);
   end

   // edges ascend, so the lowest window that holds the reading wins
   always_comb begin
      key = LKD_NONE;
      for (int k = LKD_KEYS - 1; k >= 0; k--) begin
         if (at_or_below[k]) key = lkd_key_t'(k);
      end
   end

endmodule

// File: rtl/lkd_run_filter.sv
module lkd_run_filter
   import lkd_pkg::*;
#(
   parameter int unsigned STABLE_N = 4
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     clear,
   input  logic     advance,
   input  lkd_key_t cand,
   output logic     qualified
);

   localparam int unsigned       CNT_W   = $clog2(STABLE_N + 1);
   localparam logic [CNT_W-1:0]  CNT_MAX = CNT_W'(STABLE_N);
   localparam logic [CNT_W-1:0]  CNT_ONE = CNT_W'(1);

   lkd_key_t         last_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nx;

   always_comb begin
      cnt_nx = cnt_q;
      if (advance) begin
         if (cand == last_q)
            cnt_nx = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_ONE;
         else
            cnt_nx = CNT_ONE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         last_q <= LKD_NONE;
         cnt_q  <= '0;
      end else if (advance) begin
         last_q <= cand;
         cnt_q  <= cnt_nx;
      end
   end

   assign qualified = advance && !clear && (cand != LKD_NONE) && (cnt_nx == CNT_MAX);

   // R4
   run_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (cnt_q == '0));

   // R9
   run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!advance && !clear) |=> $stable(cnt_q));

endmodule

// File: rtl/lkd_report_fsm.sv
module lkd_report_fsm
   import lkd_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     flag_hi,
   input  logic     none_seen,
   input  logic     qualified,
   input  lkd_key_t qual_key,
   output logic     key_valid,
   output lkd_key_t key_code,
   output logic     press_evt,
   output logic     release_evt
);

   typedef enum logic {ST_IDLE, ST_HELD} st_t;

   st_t st_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         key_code    <= LKD_NONE;
         press_evt   <= 1'b0;
         release_evt <= 1'b0;
      end else begin
         press_evt   <= 1'b0;
         release_evt <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (qualified) begin
                  st_q      <= ST_HELD;
                  key_code  <= qual_key;
                  press_evt <= 1'b1;
               end
            end
            ST_HELD: begin
               if (flag_hi || none_seen) begin
                  st_q        <= ST_IDLE;
                  key_code    <= LKD_NONE;
                  release_evt <= 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign key_valid = (st_q == ST_HELD);

   // R4
   flag_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_hi |=> !key_valid);

   // R8
   held_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (key_valid && $past(key_valid)) |-> $stable(key_code));

   // R6
   press_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      press_evt |=> !press_evt);

endmodule

// File: rtl/lkd_key_decoder.sv
module lkd_key_decoder
   import lkd_pkg::*;
#(
   parameter int unsigned ADC_W    = 10,
   parameter int unsigned STABLE_N = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sample_valid,
   input  logic [ADC_W-1:0] sample_code,
   input  logic             key_flag_n,
   output logic             key_valid,
   output logic [3:0]       key_code,
   output logic             press_evt,
   output logic             release_evt
);

   if (ADC_W < 10 || ADC_W > 16) begin : g_bad_width
      $error("lkd_key_decoder: ADC_W must lie in 10..16");
   end
   if (STABLE_N < 1) begin : g_bad_run
      $error("lkd_key_decoder: STABLE_N must be at least 1");
   end

   lkd_key_t cand;
   logic     qualified;
   logic     none_seen;
   lkd_key_t code_w;

   lkd_window_decode #(.ADC_W(ADC_W)) i_decode (
      .sample (sample_code),
      .key    (cand)
   );

   lkd_run_filter #(.STABLE_N(STABLE_N)) i_filter (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (key_flag_n),
      .advance   (sample_valid),
      .cand      (cand),
      .qualified (qualified)
   );

   assign none_seen = sample_valid && !key_flag_n && (cand == LKD_NONE);

   lkd_report_fsm i_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .flag_hi     (key_flag_n),
      .none_seen   (none_seen),
      .qualified   (qualified),
      .qual_key    (cand),
      .key_valid   (key_valid),
      .key_code    (code_w),
      .press_evt   (press_evt),
      .release_evt (release_evt)
   );

   assign key_code = code_w;

   // R7
   release_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      release_evt |-> (!key_valid && key_code == 4'hF));

   // R1
   idle_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !key_valid |-> (key_code == 4'hF));

   // R6
   evt_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(press_evt && release_evt));

   // R5
   rise_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(key_valid) |-> ($past(sample_valid) && !$past(key_flag_n) && press_evt));

endmodule

// File: tb/test_lkd_key_decoder.sv
module test_lkd_key_decoder;

   localparam int ADC_W = 10;
   localparam int RUN_N = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             sample_valid = 1'b0;
   logic [ADC_W-1:0] sample_code = '0;
   logic             key_flag_n = 1'b1;
   logic             key_valid;
   logic [3:0]       key_code;
   logic             press_evt;
   logic             release_evt;

   int    checks = 0;
   int    failures = 0;
   bit    done = 0;
   string cur_req = "R1";

   always #5 clk = ~clk;

   lkd_key_decoder #(.ADC_W(ADC_W), .STABLE_N(RUN_N)) i_lkd_key_decoder (
      .clk          (clk),
      .rst_n        (rst_n),
      .sample_valid (sample_valid),
      .sample_code  (sample_code),
      .key_flag_n   (key_flag_n),
      .key_valid    (key_valid),
      .key_code     (key_code),
      .press_evt    (press_evt),
      .release_evt  (release_evt)
   );

   int lv[9] = '{0, 204, 304, 398, 496, 592, 688, 784, 880};

   function automatic int edge_of(int k);
      if (k < 8) return (lv[k] + lv[k+1]) / 2;
      return (lv[8] + 1023) / 2;
   endfunction

   function automatic int ref_decode(int v);
      for (int k = 0; k < 9; k++) if (v <= edge_of(k)) return k;
      return 15;
   endfunction

   // behavioural reference state
   int m_held = 0, m_key = 15, m_last = 15, m_cnt = 0, m_press = 0, m_rel = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_held = 0; m_key = 15; m_last = 15; m_cnt = 0; m_press = 0; m_rel = 0;
      end else begin
         m_press = 0; m_rel = 0;
         if (key_flag_n) begin
            m_last = 15; m_cnt = 0;
            if (m_held == 1) begin m_held = 0; m_key = 15; m_rel = 1; end
         end else if (sample_valid) begin
            int c;
            c = ref_decode(int'(sample_code));
            if (c == m_last) m_cnt = (m_cnt < RUN_N) ? m_cnt + 1 : m_cnt;
            else begin m_cnt = 1; m_last = c; end
            if (m_held == 1) begin
               if (c == 15) begin m_held = 0; m_key = 15; m_rel = 1; end
            end else if (c != 15 && m_cnt >= RUN_N) begin
               m_held = 1; m_key = c; m_press = 1;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         int act, exp;
         act = {key_valid, press_evt, release_evt, key_code};
         exp = (m_held << 6) | (m_press << 5) | (m_rel << 4) | m_key;
         checks++;
         if (act !== exp) begin
            failures++;
            $display("FAIL %s cycle compare: actual=%b expected=%b", cur_req, act[6:0], exp[6:0]);
         end
      end
   end

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic smp(int v, int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         sample_valid = 1'b1; sample_code = ADC_W'(v); key_flag_n = 1'b0;
      end
      @(negedge clk);
      sample_valid = 1'b0;
   endtask

   task automatic idle(int n, bit f);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         sample_valid = 1'b0; key_flag_n = f;
      end
      @(negedge clk);
      key_flag_n = 1'b0;
   endtask

   initial begin
      // R1
      repeat (3) @(negedge clk);
      chk("R1 key_valid in reset", int'(key_valid), 0);
      chk("R1 key_code in reset", int'(key_code), 15);
      rst_n = 1'b1;
      idle(2, 1'b1);
      chk("R1 key_code after reset", int'(key_code), 15);

      // R5 R6
      cur_req = "R5";
      smp(204, 3);
      chk("R5 no report before run complete", int'(key_valid), 0);
      smp(204, 1);
      chk("R5 key reported", int'(key_code), 1);
      chk("R6 press pulse", int'(press_evt), 1);
      @(negedge clk);
      chk("R6 press lasts one cycle", int'(press_evt), 0);
      cur_req = "R7";
      idle(1, 1'b1);
      chk("R7 release pulse on flag", int'(release_evt), 1);
      chk("R7 code cleared", int'(key_code), 15);

      // R2 window edges
      cur_req = "R2";
      for (int k = 0; k < 9; k++) begin
         int lo;
         lo = (k == 0) ? 0 : edge_of(k - 1) + 1;
         smp(lo, RUN_N);
         chk("R2 lower edge", int'(key_code), k);
         idle(1, 1'b1);
         smp(edge_of(k), RUN_N);
         chk("R2 upper edge", int'(key_code), k);
         idle(1, 1'b1);
      end

      // R3
      cur_req = "R3";
      smp(952, 6);
      chk("R3 above top edge", int'(key_valid), 0);
      smp(1023, 6);
      chk("R3 full scale", int'(key_code), 15);

      // R4
      cur_req = "R4";
      smp(304, 3);
      idle(1, 1'b1);
      smp(304, 3);
      chk("R4 flag cleared run", int'(key_valid), 0);
      smp(304, 1);
      chk("R4 report after fresh run", int'(key_code), 2);
      idle(1, 1'b1);

      // R9
      cur_req = "R9";
      smp(398, 2);
      idle(3, 1'b0);
      smp(398, 2);
      chk("R9 gaps keep run", int'(key_code), 3);
      chk("R9 press", int'(press_evt), 1);

      // R8
      cur_req = "R8";
      smp(592, 6);
      chk("R8 other key ignored", int'(key_code), 3);
      chk("R8 no press", int'(press_evt), 0);

      // R7 release by no-key decode
      cur_req = "R7";
      smp(1000, 1);
      chk("R7 release on no-key", int'(release_evt), 1);
      chk("R7 not valid", int'(key_valid), 0);

      // R10
      cur_req = "R10";
      smp(592, 3);
      chk("R10 needs fresh run", int'(key_valid), 0);
      smp(592, 1);
      chk("R10 report", int'(key_code), 5);
      idle(1, 1'b1);

      // R5 interrupted run
      cur_req = "R5";
      smp(204, 2);
      smp(304, 1);
      smp(204, 3);
      chk("R5 broken run", int'(key_valid), 0);
      smp(204, 1);
      chk("R5 run after break", int'(key_code), 1);
      idle(2, 1'b1);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         done = 1;
         failures++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule